// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Register Target

This block is the receiving end of a shared control register through which a host programs PHY tuning bits one at a time. The host uses a simple word-indexed register bus with byte enables. It writes an 8-bit tuning address and a single data bit into the control word. It then pulses the strobe bit that belongs to one port. The block detects the rising edge of that strobe. It then stores the data bit at that address in the port's private 256-entry, one-bit tuning map.

Multi-bit fields are sent least-significant bit first, at consecutive addresses. The block decodes two of these fields for each port: the transmit amplitude and the disconnect threshold. It also keeps two common bits, PLL bandwidth and termination calibration enable, which any port's strobe can update. Three further words on the bus only store and return what was last written to them.

Top module: `phy_tune_target`

## Requirements
- R1: While rst_ni is low, all four bus words read 0, every tuning map bit is 0, and the decoded and common outputs are 0.
- R2: A write to word index 0, 1, 2 or 3 (byte offsets 0x00, 0x04, 0x08, 0x0C) is returned on bus_rdata_o for that index from the cycle after the write edge.
- R3: A bus write changes only the byte lanes whose bus_be_i bit is set. This lets the address byte (bits 15:8 of word 1) and the strobe/data byte (bits 7:0 of word 1) be written separately.
- R4: When bit 2*n of word 1 goes from 0 to 1 through a bus write, port n's map entry at the address in word 1 bits 15:8 takes the value of word 1 bit 7. The new value shows on tune_map_o bit n*256+address one cycle after that write edge.
- R5: A port's map does not change when its strobe bit stays high, stays low or falls, even if the address or data bit changes.
- R6: A strobe on one port leaves the maps of the other ports unchanged. Strobes that rise together on several ports write the same address and bit in each of those ports.
- R7: tx_amp_o for port n is its map entries 0x20 to 0x24, with entry 0x20 as the LSB.
- R8: disc_th_o for port n is its map entries 0x2A and 0x2B, with entry 0x2A as the LSB.
- R9: pll_bw_o holds the data bit of the last strobe rise on any port at address 0x03, and res_cal_en_o holds the same for address 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_idx_i | input | 2 | Word index (byte offset / 4) |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_idx_i, combinational |
| tune_map_o | output | NUM_PORTS*256 | All tuning maps, port n at bits n*256 and up |
| tx_amp_o | output | NUM_PORTS*5 | Decoded transmit amplitude per port |
| disc_th_o | output | NUM_PORTS*2 | Decoded disconnect threshold per port |
| pll_bw_o | output | 1 | Common PLL bandwidth bit |
| res_cal_en_o | output | 1 | Common termination calibration enable |

## Verification
Read data reflects a bus write from the first cycle after its edge. A tuning map entry, and the decoded and common outputs that depend on it, changes one cycle later, because the strobe edge is detected from the registered control word. Each bench write therefore drops the write strobe at the next falling edge. The bench then waits one more full clock and compares every readback word, the whole map and the decoded fields at a falling edge. This keeps the samples away from the edges at which the outputs change.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int TUNE_AW   = 8;
  localparam int MAP_W     = 1 << TUNE_AW;
  localparam int DATA_BIT  = 7;
  localparam int ADDR_LSB  = 8;
  localparam int CTRL_IDX  = 1;
  localparam int AMP_BASE  = 'h20;
  localparam int AMP_W     = 5;
  localparam int DISC_BASE = 'h2A;
  localparam int DISC_W    = 2;
  localparam logic [TUNE_AW-1:0] PLL_ADDR  = 8'h03;
  localparam logic [TUNE_AW-1:0] RCAL_ADDR = 8'h0C;
endpackage

// File: rtl/phy_tune_regs.sv
module phy_tune_regs
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DW        = 32,
  parameter int NWORDS    = 4,
  localparam int IW       = $clog2(NWORDS),
  localparam int NB       = DW / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [NB-1:0]      be_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [TUNE_AW-1:0] tune_addr_o,
  output logic               tune_data_o,
  output logic [NUM_PORTS-1:0] strobe_o
);
  logic [DW-1:0] regs_q [NWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NWORDS; r++) regs_q[r] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NB; b++)
        if (be_i[b]) regs_q[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o     = regs_q[idx_i];
  assign tune_addr_o = regs_q[CTRL_IDX][ADDR_LSB +: TUNE_AW];
  assign tune_data_o = regs_q[CTRL_IDX][DATA_BIT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strb
    assign strobe_o[p] = regs_q[CTRL_IDX][2*p];
  end
endmodule

// File: rtl/phy_tune_port.sv
module phy_tune_port
  import phy_tune_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [TUNE_AW-1:0] addr_i,
  input  logic               data_i,
  output logic               rise_o,
  output logic [MAP_W-1:0]   map_o
);
  logic             prev_q;
  logic [MAP_W-1:0] map_q;

  assign rise_o = strobe_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      map_q  <= '0;
    end else begin
      prev_q <= strobe_i;
      if (rise_o) map_q[addr_i] <= data_i;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/phy_tune_common.sv
module phy_tune_common
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] rise_i,
  input  logic [TUNE_AW-1:0]   addr_i,
  input  logic                 data_i,
  output logic                 pll_bw_o,
  output logic                 res_cal_en_o
);
  // all ports share one address field and data bit, so concurrent rises agree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_bw_o     <= 1'b0;
      res_cal_en_o <= 1'b0;
    end else if (|rise_i) begin
      if (addr_i == PLL_ADDR)  pll_bw_o     <= data_i;
      if (addr_i == RCAL_ADDR) res_cal_en_o <= data_i;
    end
  end
endmodule

// File: rtl/phy_tune_target.sv
module phy_tune_target
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_we_i,
  input  logic [1:0]                   bus_idx_i,
  input  logic [3:0]                   bus_be_i,
  input  logic [31:0]                  bus_wdata_i,
  output logic [31:0]                  bus_rdata_o,
  output logic [NUM_PORTS*MAP_W-1:0]   tune_map_o,
  output logic [NUM_PORTS*AMP_W-1:0]   tx_amp_o,
  output logic [NUM_PORTS*DISC_W-1:0]  disc_th_o,
  output logic                         pll_bw_o,
  output logic                         res_cal_en_o
);
  logic [TUNE_AW-1:0]   tune_addr;
  logic                 tune_data;
  logic [NUM_PORTS-1:0] strobe;
  logic [NUM_PORTS-1:0] rise_vec;

  phy_tune_regs #(.NUM_PORTS(NUM_PORTS), .DW(32), .NWORDS(4)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .idx_i       (bus_idx_i),
    .be_i        (bus_be_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .tune_addr_o (tune_addr),
    .tune_data_o (tune_data),
    .strobe_o    (strobe)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    phy_tune_port u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe[p]),
      .addr_i   (tune_addr),
      .data_i   (tune_data),
      .rise_o   (rise_vec[p]),
      .map_o    (tune_map_o[p*MAP_W +: MAP_W])
    );
    assign tx_amp_o[p*AMP_W +: AMP_W]   = tune_map_o[p*MAP_W + AMP_BASE +: AMP_W];
    assign disc_th_o[p*DISC_W +: DISC_W] = tune_map_o[p*MAP_W + DISC_BASE +: DISC_W];
  end

  phy_tune_common #(.NUM_PORTS(NUM_PORTS)) u_common (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise_vec),
    .addr_i       (tune_addr),
    .data_i       (tune_data),
    .pll_bw_o     (pll_bw_o),
    .res_cal_en_o (res_cal_en_o)
  );
endmodule

// File: rtl/phy_tune_target_chk.sv
module phy_tune_target_chk
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_we_i,
  input logic [1:0]                 bus_idx_i,
  input logic [3:0]                 bus_be_i,
  input logic [NUM_PORTS-1:0]       rise_vec,
  input logic [TUNE_AW-1:0]         tune_addr,
  input logic                       tune_data,
  input logic [NUM_PORTS*MAP_W-1:0] tune_map_o,
  input logic                       pll_bw_o,
  input logic                       res_cal_en_o
);
  logic pll_hit, rcal_hit;
  assign pll_hit  = (|rise_vec) && (tune_addr == PLL_ADDR);
  assign rcal_hit = (|rise_vec) && (tune_addr == RCAL_ADDR);

  a_r3_addr_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_idx_i == 2'd1 && !bus_be_i[1]) |=> $stable(tune_addr));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    a_r4_strobe_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_vec[p] |=> tune_map_o[p*MAP_W + int'($past(tune_addr))] == $past(tune_data));
    a_r5_map_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise_vec[p] |=> $stable(tune_map_o[p*MAP_W +: MAP_W]));
  end

  a_r9_pll_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_hit |=> pll_bw_o == $past(tune_data));
  a_r9_pll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_hit |=> $stable(pll_bw_o));
  a_r9_rcal_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcal_hit |=> res_cal_en_o == $past(tune_data));
  a_r9_rcal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rcal_hit |=> $stable(res_cal_en_o));
endmodule

bind phy_tune_target phy_tune_target_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .bus_idx_i    (bus_idx_i),
  .bus_be_i     (bus_be_i),
  .rise_vec     (rise_vec),
  .tune_addr    (tune_addr),
  .tune_data    (tune_data),
  .tune_map_o   (tune_map_o),
  .pll_bw_o     (pll_bw_o),
  .res_cal_en_o (res_cal_en_o)
);

// File: tb/phy_tune_target_bench.sv
module phy_tune_target_bench;
  localparam int NP   = 3;
  localparam int MW   = 256;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [1:0]        bus_idx_i = '0;
  logic [3:0]        bus_be_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic [NP*MW-1:0]  tune_map_o;
  logic [NP*5-1:0]   tx_amp_o;
  logic [NP*2-1:0]   disc_th_o;
  logic              pll_bw_o, res_cal_en_o;

  phy_tune_target #(.NUM_PORTS(NP)) u_phy_tune_target (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0]      exp_regs [4];
  logic [NP*MW-1:0] exp_map;
  logic             exp_pll, exp_rcal;

  function automatic logic [4:0] exp_amp(int p);
    logic [4:0] v;
    for (int i = 0; i < 5; i++) v[i] = exp_map[p*MW + 'h20 + i];
    return v;
  endfunction

  function automatic logic [1:0] exp_disc(int p);
    return {exp_map[p*MW + 'h2B], exp_map[p*MW + 'h2A]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // model: byte-lane update, then strobe rise per port against the old word
  task automatic model_write(logic [1:0] idx, logic [3:0] be, logic [31:0] d);
    logic [31:0] old_w, new_w;
    old_w = exp_regs[idx];
    new_w = old_w;
    for (int b = 0; b < 4; b++) if (be[b]) new_w[b*8 +: 8] = d[b*8 +: 8];
    exp_regs[idx] = new_w;
    if (idx == 2'd1) begin
      for (int p = 0; p < NP; p++) begin
        if (new_w[2*p] && !old_w[2*p]) begin
          exp_map[p*MW + int'(new_w[15:8])] = new_w[7];
          if (new_w[15:8] == 8'h03) exp_pll  = new_w[7];
          if (new_w[15:8] == 8'h0C) exp_rcal = new_w[7];
        end
      end
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_idx_i = idx; bus_be_i = be; bus_wdata_i = d;
    model_write(idx, be, d);
    @(negedge clk_i);
    bus_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) begin
      bus_idx_i = 2'(i);
      #1;
      chk({"R2/R3 readback ", tag}, 64'(bus_rdata_o), 64'(exp_regs[i]));
    end
    for (int p = 0; p < NP; p++) begin
      chk({"R4/R5/R6 map ", tag}, 64'(tune_map_o[p*MW +: 64]) ^ 64'(tune_map_o[p*MW+64 +: 64]) ^
          64'(tune_map_o[p*MW+128 +: 64]) ^ 64'(tune_map_o[p*MW+192 +: 64]),
          64'(exp_map[p*MW +: 64]) ^ 64'(exp_map[p*MW+64 +: 64]) ^
          64'(exp_map[p*MW+128 +: 64]) ^ 64'(exp_map[p*MW+192 +: 64]));
      chk({"R7 tx_amp ", tag}, 64'(tx_amp_o[p*5 +: 5]), 64'(exp_amp(p)));
      chk({"R8 disc_th ", tag}, 64'(disc_th_o[p*2 +: 2]), 64'(exp_disc(p)));
    end
    checks++;
    if (tune_map_o !== exp_map) begin
      errors++;
      $display("FAIL R4/R5/R6 full map %s actual differs expected", tag);
    end
    chk({"R9 pll_bw ", tag}, 64'(pll_bw_o), 64'(exp_pll));
    chk({"R9 res_cal ", tag}, 64'(res_cal_en_o), 64'(exp_rcal));
  endtask

  // driver-style bit write on one port, LSB-first fields handled by caller
  task automatic tune_bit(int p, logic [7:0] a, logic b);
    logic [7:0] lo;
    wr(2'd1, 4'b0010, {16'h0, a, 8'h0});
    lo = exp_regs[1][7:0];
    lo[7] = b; lo[2*p] = 1'b0;
    wr(2'd1, 4'b0001, {24'h0, lo});
    lo[2*p] = 1'b1;
    wr(2'd1, 4'b0001, {24'h0, lo});
    lo[2*p] = 1'b0;
    wr(2'd1, 4'b0001, {24'h0, lo});
  endtask

  task automatic tune_field(int p, logic [7:0] base, int w, logic [31:0] v);
    for (int i = 0; i < w; i++) tune_bit(p, base + 8'(i), v[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) exp_regs[i] = '0;
    exp_map = '0; exp_pll = 0; exp_rcal = 0;
    repeat (2) @(negedge clk_i);
    // R1: outputs during reset
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: all four words
    wr(2'd0, 4'hF, 32'hA5A5_0001); wr(2'd2, 4'hF, 32'h1234_5678); wr(2'd3, 4'hF, 32'hDEAD_BEEF);
    check_all("R2 words");
    // R3: partial lanes
    wr(2'd2, 4'b0100, 32'hFFFF_FFFF); wr(2'd3, 4'b0000, 32'h0);
    check_all("R3 lanes");

    // R7: amplitude 0x14 on port 1, R8: disc threshold 3 on port 2
    tune_field(1, 8'h20, 5, 32'h14);
    check_all("R7 amp port1");
    chk("R7 amp port1 value", 64'(tx_amp_o[5 +: 5]), 64'h14);
    tune_field(2, 8'h2A, 2, 32'h3);
    chk("R8 disc port2 value", 64'(disc_th_o[4 +: 2]), 64'h3);
    chk("R6 port0 amp untouched", 64'(tx_amp_o[0 +: 5]), 64'h0);

    // R9: common bits through different ports
    tune_bit(0, 8'h03, 1'b1);
    tune_bit(2, 8'h0C, 1'b1);
    check_all("R9 common set");
    chk("R9 pll set", 64'(pll_bw_o), 64'h1);
    tune_bit(1, 8'h03, 1'b0);
    chk("R9 pll cleared by other port", 64'(pll_bw_o), 64'h0);

    // R5: strobe held high while address and data change
    wr(2'd1, 4'h3, 32'h0000_4081);
    wr(2'd1, 4'h3, 32'h0000_4101);
    wr(2'd1, 4'h3, 32'h0000_4201);
    check_all("R5 held high");
    chk("R5 no write at 0x41", 64'(tune_map_o[0*MW + 'h41]), 64'h0);
    wr(2'd1, 4'h3, 32'h0000_4380);   // falling strobe, no write
    chk("R5 falling no write", 64'(tune_map_o[0*MW + 'h43]), 64'h0);

    // R6: simultaneous rise on all ports
    wr(2'd1, 4'h3, 32'h0000_5080);
    wr(2'd1, 4'h1, 32'h0000_0095);
    check_all("R6 all ports");
    for (int p = 0; p < NP; p++)
      chk("R6 simultaneous write", 64'(tune_map_o[p*MW + 'h50]), 64'h1);
    wr(2'd1, 4'h1, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] idx;
      logic [31:0] d;
      idx = ($urandom % 3 == 0) ? 2'($urandom) : 2'd1;
      d = $urandom;
      if ($urandom % 2 == 0) d[15:8] = 8'h20 + 8'($urandom % 12);
      wr(idx, 4'($urandom), d);
      check_all("R4 random");
    end

    summary();
  end
endmodule